// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block starts a clocked media subsystem from a cold state. On a start request it first lifts the interface isolation and releases the subsystem reset. It then checks that the PLL output divider is set to divide-by-2. It loads the PLL feedback divider and four clock divisors, writes the loop-filter word, and runs the PLL through bypass, reset and lock. Every field update is a read-modify-write over a single-strobe register port. Only one access is in flight at any time.

The divider and filter settings are computed elsewhere. They are presented on input ports and must stay stable while the block is busy. A timeout tick (typically one per millisecond) drives the lock watchdog, which is a parameterised count of ticks. When the sequence ends, exactly one sticky outcome flag is set: success, lock timeout or bad divider configuration. A shutdown request issued while idle puts isolation and reset back.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset the block is idle: no read or write strobe, `busy` low, and all three outcome flags low.
- R2: On `start` while idle, the first access is a write of 0x3 to the isolation register (bit 0 lifts isolation, bit 1 releases the subsystem reset).
- R3: The second access reads the PLL control register. If bits 17:16 of the read data are not 01, `err_cfg` is set, the sequence ends at once and no further access is made.
- R4: The PLL control write that follows places `fb_div` in bits 14:8, clears bits 2 and 1, and keeps every other bit as read.
- R5: The four clock registers are then each read and rewritten, in the order encoder core, decoder core, encoder MCU, decoder MCU. Bits 9:4 get `core_div` for the two core registers and `mcu_div` for the two MCU registers, and bit 0 is set to 1 to select the PLL. All other bits keep their read value.
- R6: After the clock registers, `loop_cfg` is written unchanged to the loop-filter register.
- R7: Three read-modify-writes of the PLL control register follow, in this order: set bit 3 (bypass), set bit 0 (reset), clear bit 0. Each changes only its own bit.
- R8: Once `pll_locked` is seen high after the reset release, a final read-modify-write clears bit 3 and `lock_ok` is set. No access takes place between the reset release and the lock.
- R9: If `LOCK_TIMEOUT_TICKS` timeout ticks pass in the lock wait without lock, `err_timeout` is set and no further access is made, so bypass stays set. Lock wins if both occur in the same cycle.
- R10: Each strobe lasts one cycle. Read and write never assert together. No new strobe is issued until the previous access has been acknowledged.
- R11: `shutdown` while idle writes 0 to the isolation register. `start` and `shutdown` arriving while busy are ignored.
- R12: The outcome flags hold their value until the next accepted `start`, which clears all three in the cycle it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up sequence (taken only when idle) |
| shutdown | input | 1 | Restore isolation and reset (taken only when idle) |
| fb_div | input | 7 | PLL feedback divider |
| core_div | input | 6 | Divisor for both core clocks |
| mcu_div | input | 6 | Divisor for both MCU clocks |
| loop_cfg | input | 32 | Packed loop-filter configuration word |
| pll_locked | input | 1 | PLL lock status |
| tmo_tick | input | 1 | Time base for the lock watchdog |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_addr | output | AW | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completion |
| busy | output | 1 | Sequence in progress |
| lock_ok | output | 1 | Sequence finished with the PLL locked |
| err_timeout | output | 1 | Lock not seen within the tick budget |
| err_cfg | output | 1 | Output divider field was not divide-by-2 |

## Verification
The bench preloads the register model with random contents and compares every access, in order, against a trace rebuilt from the requirements. A merge that clobbered neighbouring bits, or a wrong clock register order, shows up as a data mismatch. Each non-01 divider code is applied directly; a design that accepted one would emit a PLL control write where the trace has none. The bench runs lock arriving before the wait, during it and never. It also measures the timeout against the ticks counted, so an off-by-many counter or a bypass release after a timeout is flagged. Start and shutdown pulses injected mid-run would add or reorder accesses in a design that honoured them.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int REG_W      = 32;
    localparam int FB_W       = 7;
    localparam int DIV_W      = 6;
    localparam int FB_LSB     = 8;
    localparam int DIV_LSB    = 4;
    localparam int ODIV_LSB   = 16;
    localparam int ODIV_W     = 2;
    localparam int BYP_BIT    = 3;
    localparam int RST_BIT    = 0;
    localparam int POR_A_BIT  = 1;
    localparam int POR_B_BIT  = 2;
    localparam int SRC_BIT    = 0;
    localparam int N_CLK_REGS = 4;

    localparam logic [ODIV_W-1:0] ODIV_HALF   = 2'd1;
    localparam logic [REG_W-1:0]  ISO_RELEASE = 32'h0000_0003;
    localparam logic [REG_W-1:0]  ISO_ENGAGE  = 32'h0000_0000;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ISO_WR,
        S_CTRL_RD,
        S_CTRL_WR,
        S_CLK_RD,
        S_CLK_WR,
        S_LF_WR,
        S_SEQ_RD,
        S_SEQ_WR,
        S_LOCK_WAIT,
        S_SHUT_WR
    } seq_state_e;

    typedef enum logic [2:0] {
        MO_NONE,
        MO_FBDIV,
        MO_CLKDIV,
        MO_BYP_SET,
        MO_RST_SET,
        MO_RST_CLR,
        MO_BYP_CLR
    } merge_op_e;

endpackage

// File: rtl/pll_seq_merge.sv
module pll_seq_merge
    import pll_seq_pkg::*;
(
    input  merge_op_e         op,
    input  logic [REG_W-1:0]  old_word,
    input  logic [FB_W-1:0]   fb,
    input  logic [DIV_W-1:0]  dv,
    output logic [REG_W-1:0]  new_word
);

    always_comb begin
        new_word = old_word;
        unique case (op)
            MO_FBDIV: begin
                new_word[FB_LSB +: FB_W] = fb;
                new_word[POR_A_BIT]      = 1'b0;
                new_word[POR_B_BIT]      = 1'b0;
            end
            MO_CLKDIV: begin
                new_word[DIV_LSB +: DIV_W] = dv;
                new_word[SRC_BIT]          = 1'b1;
            end
            MO_BYP_SET: new_word[BYP_BIT] = 1'b1;
            MO_RST_SET: new_word[RST_BIT] = 1'b1;
            MO_RST_CLR: new_word[RST_BIT] = 1'b0;
            MO_BYP_CLR: new_word[BYP_BIT] = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LIM_V) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q == LIM_V);

    // R9
    expire_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_q == LIM_V) |-> $past(tick && en));

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int AW                 = 8,
    parameter int LOCK_TIMEOUT_TICKS = 2000,
    parameter logic [AW-1:0] A_ISO      = 8'h00,
    parameter logic [AW-1:0] A_PLL_CTRL = 8'h04,
    parameter logic [AW-1:0] A_LOOP     = 8'h08,
    parameter logic [AW-1:0] A_ENC_CORE = 8'h10,
    parameter logic [AW-1:0] A_DEC_CORE = 8'h14,
    parameter logic [AW-1:0] A_ENC_MCU  = 8'h18,
    parameter logic [AW-1:0] A_DEC_MCU  = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shutdown,
    input  logic [FB_W-1:0]   fb_div,
    input  logic [DIV_W-1:0]  core_div,
    input  logic [DIV_W-1:0]  mcu_div,
    input  logic [REG_W-1:0]  loop_cfg,
    input  logic              pll_locked,
    input  logic              tmo_tick,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [AW-1:0]     bus_addr,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  bus_rdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              lock_ok,
    output logic              err_timeout,
    output logic              err_cfg
);

    localparam int IW = $clog2(N_CLK_REGS);
    localparam logic [IW-1:0] LAST_CLK = IW'(N_CLK_REGS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              pend;
        logic              rd;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [REG_W-1:0]  wdata;
        logic [REG_W-1:0]  shadow;
        logic [IW-1:0]     clk_idx;
        logic [1:0]        seq_idx;
        logic              ok;
        logic              err_to;
        logic              err_cf;
    } seq_regs_t;

    seq_regs_t d, q;

    merge_op_e         m_op;
    logic [DIV_W-1:0]  m_div;
    logic [REG_W-1:0]  merged;
    logic [AW-1:0]     clk_addr;
    logic              want_rd, want_wr;
    logic [AW-1:0]     want_addr;
    logic [REG_W-1:0]  want_data;
    logic              tmo_expired;

    pll_seq_merge u_merge (
        .op       (m_op),
        .old_word (q.shadow),
        .fb       (fb_div),
        .dv       (m_div),
        .new_word (merged)
    );

    pll_seq_timer #(.LIMIT(LOCK_TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (q.st == S_LOCK_WAIT),
        .tick    (tmo_tick),
        .expired (tmo_expired)
    );

    // clock register walk order and divisor selection
    always_comb begin
        unique case (q.clk_idx)
            2'd0:    clk_addr = A_ENC_CORE;
            2'd1:    clk_addr = A_DEC_CORE;
            2'd2:    clk_addr = A_ENC_MCU;
            default: clk_addr = A_DEC_MCU;
        endcase
        m_div = (q.clk_idx < IW'(2)) ? core_div : mcu_div;
    end

    // access wanted in the current state
    always_comb begin
        want_rd   = 1'b0;
        want_wr   = 1'b0;
        want_addr = A_PLL_CTRL;
        want_data = merged;
        m_op      = MO_NONE;
        unique case (q.st)
            S_ISO_WR: begin
                want_wr = 1'b1; want_addr = A_ISO; want_data = ISO_RELEASE;
            end
            S_CTRL_RD: want_rd = 1'b1;
            S_CTRL_WR: begin
                want_wr = 1'b1; m_op = MO_FBDIV;
            end
            S_CLK_RD: begin
                want_rd = 1'b1; want_addr = clk_addr;
            end
            S_CLK_WR: begin
                want_wr = 1'b1; want_addr = clk_addr; m_op = MO_CLKDIV;
            end
            S_LF_WR: begin
                want_wr = 1'b1; want_addr = A_LOOP; want_data = loop_cfg;
            end
            S_SEQ_RD: want_rd = 1'b1;
            S_SEQ_WR: begin
                want_wr = 1'b1;
                unique case (q.seq_idx)
                    2'd0:    m_op = MO_BYP_SET;
                    2'd1:    m_op = MO_RST_SET;
                    2'd2:    m_op = MO_RST_CLR;
                    default: m_op = MO_BYP_CLR;
                endcase
            end
            S_SHUT_WR: begin
                want_wr = 1'b1; want_addr = A_ISO; want_data = ISO_ENGAGE;
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        d    = q;
        d.rd = 1'b0;
        d.wr = 1'b0;
        if (q.st == S_IDLE) begin
            if (start) begin
                d.ok     = 1'b0;
                d.err_to = 1'b0;
                d.err_cf = 1'b0;
                d.st     = S_ISO_WR;
            end else if (shutdown) begin
                d.st = S_SHUT_WR;
            end
        end else if (q.st == S_LOCK_WAIT) begin
            if (pll_locked) begin
                d.seq_idx = 2'd3;
                d.st      = S_SEQ_RD;
            end else if (tmo_expired) begin
                d.err_to = 1'b1;
                d.st     = S_IDLE;
            end
        end else if (!q.pend) begin
            d.rd    = want_rd;
            d.wr    = want_wr;
            d.addr  = want_addr;
            d.wdata = want_data;
            d.pend  = 1'b1;
        end else if (bus_ack) begin
            d.pend = 1'b0;
            if (want_rd) d.shadow = bus_rdata;
            unique case (q.st)
                S_ISO_WR:  d.st = S_CTRL_RD;
                S_CTRL_RD: begin
                    if (bus_rdata[ODIV_LSB +: ODIV_W] != ODIV_HALF) begin
                        d.err_cf = 1'b1;
                        d.st     = S_IDLE;
                    end else begin
                        d.st = S_CTRL_WR;
                    end
                end
                S_CTRL_WR: begin
                    d.clk_idx = '0;
                    d.st      = S_CLK_RD;
                end
                S_CLK_RD:  d.st = S_CLK_WR;
                S_CLK_WR: begin
                    if (q.clk_idx == LAST_CLK) begin
                        d.st = S_LF_WR;
                    end else begin
                        d.clk_idx = q.clk_idx + 1'b1;
                        d.st      = S_CLK_RD;
                    end
                end
                S_LF_WR: begin
                    d.seq_idx = 2'd0;
                    d.st      = S_SEQ_RD;
                end
                S_SEQ_RD:  d.st = S_SEQ_WR;
                S_SEQ_WR: begin
                    unique case (q.seq_idx)
                        2'd2: d.st = S_LOCK_WAIT;
                        2'd3: begin
                            d.ok = 1'b1;
                            d.st = S_IDLE;
                        end
                        default: begin
                            d.seq_idx = q.seq_idx + 1'b1;
                            d.st      = S_SEQ_RD;
                        end
                    endcase
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_rd      = q.rd;
    assign bus_wr      = q.wr;
    assign bus_addr    = q.addr;
    assign bus_wdata   = q.wdata;
    assign busy        = (q.st != S_IDLE);
    assign lock_ok     = q.ok;
    assign err_timeout = q.err_to;
    assign err_cfg     = q.err_cf;

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R10
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));

    // R2
    iso_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ISO) |->
            (bus_wdata == ISO_RELEASE || bus_wdata == ISO_ENGAGE));

    // R5
    clk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_ENC_CORE || bus_addr == A_DEC_CORE ||
                    bus_addr == A_ENC_MCU  || bus_addr == A_DEC_MCU))
            |-> bus_wdata[SRC_BIT]);

    // R9
    timeout_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> $past(!pll_locked));

    // R3
    cfg_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_cfg) |-> (!busy && !lock_ok));

endmodule

// File: tb/pll_bringup_seq_bench.sv
module pll_bringup_seq_bench;

    localparam int LIM = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        shutdown = 1'b0;
    logic [6:0]  fb_div = '0;
    logic [5:0]  core_div = '0;
    logic [5:0]  mcu_div = '0;
    logic [31:0] loop_cfg = '0;
    logic        pll_locked = 1'b0;
    logic        tmo_tick = 1'b0;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        busy, lock_ok, err_timeout, err_cfg;

    pll_bringup_seq #(.LOCK_TIMEOUT_TICKS(LIM)) u_pll_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .shutdown(shutdown),
        .fb_div(fb_div), .core_div(core_div), .mcu_div(mcu_div),
        .loop_cfg(loop_cfg), .pll_locked(pll_locked), .tmo_tick(tmo_tick),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .lock_ok(lock_ok), .err_timeout(err_timeout),
        .err_cfg(err_cfg)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;

    // register model and access trace
    logic [31:0] mem [0:7];
    bit          tr_wr   [0:511];
    logic [7:0]  tr_addr [0:511];
    logic [31:0] tr_data [0:511];
    int          tr_n = 0;
    bit          pend_m = 0;
    logic [7:0]  m_addr = '0;
    int          dly = 0;
    int          overlap_err = 0;
    int          tick_cnt = 0;
    int          tick_at_ack = 0;
    int          tdiv = 0;
    int          base = 0;
    int          lock_mode = 0;
    int          lock_delay = 0;
    int          lock_cnt = 0;

    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (bus_rd || bus_wr) begin
            if (pend_m) overlap_err <= overlap_err + 1;
            pend_m  <= 1'b1;
            m_addr  <= bus_addr;
            dly     <= int'($urandom_range(0, 3));
            tr_wr[tr_n]   <= bus_wr;
            tr_addr[tr_n] <= bus_addr;
            tr_data[tr_n] <= bus_wdata;
            tr_n          <= tr_n + 1;
            if (bus_wr) mem[bus_addr[4:2]] <= bus_wdata;
        end else if (pend_m) begin
            if (dly == 0) begin
                bus_ack   <= 1'b1;
                bus_rdata <= mem[m_addr[4:2]];
                pend_m    <= 1'b0;
                if (tr_n - base == 18) tick_at_ack <= tick_cnt;
            end else begin
                dly <= dly - 1;
            end
        end
    end

    always @(posedge clk) begin
        tdiv     <= (tdiv == 2) ? 0 : tdiv + 1;
        tmo_tick <= (tdiv == 2);
        if (tmo_tick) tick_cnt <= tick_cnt + 1;
    end

    always @(posedge clk) begin
        if (lock_mode == 2) begin
            pll_locked <= 1'b1;
        end else if (lock_mode == 1 && tr_n - base >= 18) begin
            if (lock_cnt == 0) pll_locked <= 1'b1;
            else lock_cnt <= lock_cnt - 1;
        end else begin
            pll_locked <= 1'b0;
            lock_cnt   <= lock_delay;
        end
    end

    // expected trace
    bit          ex_wr   [0:31];
    logic [7:0]  ex_addr [0:31];
    logic [31:0] ex_data [0:31];
    string       ex_req  [0:31];
    int          ex_n = 0;

    function automatic logic [31:0] exp_ctrl_fb(logic [31:0] c, logic [6:0] fb);
        return (c & ~32'h0000_7F06) | ({25'd0, fb} << 8);
    endfunction

    function automatic logic [31:0] exp_clk(logic [31:0] k, logic [5:0] dv);
        return (k & ~32'h0000_03F0) | ({26'd0, dv} << 4) | 32'h1;
    endfunction

    task automatic push(bit w, logic [7:0] a, logic [31:0] dat, string rq);
        ex_wr[ex_n] = w; ex_addr[ex_n] = a; ex_data[ex_n] = dat; ex_req[ex_n] = rq;
        ex_n++;
    endtask

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, expv);
        end
    endtask

    task automatic build_exp(int kind, logic [31:0] c0, logic [31:0] k [4]);
        logic [31:0] c;
        logic [7:0]  ca [4];
        ca[0] = 8'h10; ca[1] = 8'h14; ca[2] = 8'h18; ca[3] = 8'h1C;
        ex_n = 0;
        push(1, 8'h00, 32'h3, "R2");
        push(0, 8'h04, 32'h0, "R3");
        if (kind == 1) return;
        c = exp_ctrl_fb(c0, fb_div);
        push(1, 8'h04, c, "R4");
        for (int i = 0; i < 4; i++) begin
            push(0, ca[i], 32'h0, "R5");
            push(1, ca[i], exp_clk(k[i], (i < 2) ? core_div : mcu_div), "R5");
        end
        push(1, 8'h08, loop_cfg, "R6");
        c = c | 32'h8;  push(0, 8'h04, 0, "R7"); push(1, 8'h04, c, "R7");
        c = c | 32'h1;  push(0, 8'h04, 0, "R7"); push(1, 8'h04, c, "R7");
        c = c & ~32'h1; push(0, 8'h04, 0, "R7"); push(1, 8'h04, c, "R7");
        if (kind == 0) begin
            c = c & ~32'h8; push(0, 8'h04, 0, "R8"); push(1, 8'h04, c, "R8");
        end
    endtask

    task automatic compare_trace();
        chk(tr_n - base == ex_n, "R10", "access count", 32'(tr_n - base), 32'(ex_n));
        for (int i = 0; i < ex_n && i < tr_n - base; i++) begin
            chk(tr_wr[base+i] == ex_wr[i] && tr_addr[base+i] == ex_addr[i],
                ex_req[i], "kind/addr", {23'd0, tr_wr[base+i], tr_addr[base+i]},
                {23'd0, ex_wr[i], ex_addr[i]});
            if (ex_wr[i])
                chk(tr_data[base+i] == ex_data[i], ex_req[i], "wdata",
                    tr_data[base+i], ex_data[i]);
        end
    endtask

    // kind: 0 lock, 1 divider error, 2 timeout
    task automatic run_case(int kind, logic [31:0] c0, int lm, bit poke);
        logic [31:0] k [4];
        int t_end;
        for (int i = 0; i < 4; i++) k[i] = $urandom;
        fb_div   = 7'($urandom);
        core_div = 6'($urandom);
        mcu_div  = 6'($urandom);
        loop_cfg = $urandom;
        @(negedge clk);
        mem[0] = $urandom; mem[1] = c0; mem[2] = $urandom;
        for (int i = 0; i < 4; i++) mem[4+i] = k[i];
        lock_delay = int'($urandom_range(0, 30));
        lock_mode  = lm;
        base = tr_n;
        build_exp(kind, c0, k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R12: flags cleared when start is taken
        chk(!lock_ok && !err_timeout && !err_cfg && busy, "R12", "flags on start",
            {28'd0, busy, lock_ok, err_timeout, err_cfg}, 32'h8);
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1; shutdown = 1'b1;
            @(negedge clk);
            start = 1'b0; shutdown = 1'b0;
        end
        while (busy) @(negedge clk);
        t_end = tick_cnt;
        repeat (3) @(negedge clk);
        compare_trace();
        if (kind == 0)
            chk(lock_ok && !err_timeout && !err_cfg, "R8", "outcome",
                {29'd0, lock_ok, err_timeout, err_cfg}, 32'h4);
        if (kind == 1)
            chk(!lock_ok && !err_timeout && err_cfg, "R3", "outcome",
                {29'd0, lock_ok, err_timeout, err_cfg}, 32'h1);
        if (kind == 2) begin
            chk(!lock_ok && err_timeout && !err_cfg, "R9", "outcome",
                {29'd0, lock_ok, err_timeout, err_cfg}, 32'h2);
            chk(t_end - tick_at_ack >= LIM && t_end - tick_at_ack <= LIM + 1,
                "R9", "ticks waited", 32'(t_end - tick_at_ack), 32'(LIM));
            chk(mem[1][3], "R9", "bypass left set", mem[1], mem[1] | 32'h8);
        end
        lock_mode = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd1207));
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: idle after reset
        chk(!busy && !bus_rd && !bus_wr && !lock_ok && !err_timeout && !err_cfg,
            "R1", "reset state",
            {26'd0, busy, bus_rd, bus_wr, lock_ok, err_timeout, err_cfg}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_rd && !bus_wr, "R1", "idle after release",
            {29'd0, busy, bus_rd, bus_wr}, 32'h0);

        // lock already high when the wait begins
        run_case(0, ($urandom & ~32'h0003_0000) | 32'h0001_0000, 2, 0);
        // random settings, lock arriving during the wait
        for (int n = 0; n < 7; n++)
            run_case(0, ($urandom & ~32'h0003_0000) | 32'h0001_0000, 1, n == 2);
        // bad output-divider codes (R3)
        run_case(1, ($urandom & ~32'h0003_0000), 1, 0);
        run_case(1, ($urandom & ~32'h0003_0000) | 32'h0002_0000, 1, 0);
        run_case(1, $urandom | 32'h0003_0000, 1, 0);
        // no lock at all (R9), with ignored requests mid-run (R11)
        run_case(2, ($urandom & ~32'h0003_0000) | 32'h0001_0000, 0, 1);
        // R12: a new start after an error clears the flags
        run_case(0, ($urandom & ~32'h0003_0000) | 32'h0001_0000, 1, 0);

        // R11: shutdown while idle
        base = tr_n;
        mem[0] = 32'h3;
        shutdown = 1'b1;
        @(negedge clk);
        shutdown = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(tr_n - base == 1, "R11", "shutdown access count", 32'(tr_n - base), 32'd1);
        chk(tr_wr[base] && tr_addr[base] == 8'h00 && tr_data[base] == 32'h0,
            "R11", "shutdown write", tr_data[base], 32'h0);
        chk(mem[0] == 32'h0, "R11", "isolation register", mem[0], 32'h0);

        // R10: no strobe while an access was pending
        chk(overlap_err == 0, "R10", "overlapping strobes", 32'(overlap_err), 32'd0);

        report();
        $finish;
    end

endmodule